// File: doc/BRIEF.md
# Clock Device Boot Configuration Sequencer

This block runs once after reset and brings three external clock devices into their working state: an RF reference buffer, a sampling-clock buffer and a PLL. It first waits a settling delay and fills a 128-byte scratch RAM with 0xFF. It then reads a two-byte signature from a configuration EEPROM through a byte-read handshake. A matching signature selects the EEPROM as the source of settings. A wrong or unreadable signature selects a built-in default table, which is computed from parameters.

Three switch inputs report which clock module is fitted and which of three configuration sets (A, B, C) to use. The block copies address/data byte pairs for each device into the scratch RAM. It then issues one SPI register write per pair through a request/acknowledge handshake to an SPI writer. When a PLL module is fitted, the PLL writes are held back until the reference clock is reported valid, and completion waits for PLL lock. At the end, the block asserts a permanent done flag and leaves all its bus outputs at zero.

Top module: `clkcfg_boot_seq`

## Requirements
- R1: After reset the block issues no EEPROM request for DELAY_CYCLES cycles plus 128 cycles (settling delay, then scratch fill with 0xFF), and cfg_done, cfg_err, ee_req and spi_req are 0.
- R2: The first EEPROM reads are byte 15000 and then byte 15001. The EEPROM is used only if they hold 0xA5 and 0xCD. A wrong value or a read error on either byte selects the default tables, performs no further EEPROM reads and leaves cfg_err at 0.
- R3: Switch bits [1:0] = 3 means no module is fitted. Otherwise switch bit 2 = 0 means a PLL module and bit 2 = 1 means a buffer-only module. Only a PLL module raises refmon_en.
- R4: Switch bits [1:0] = 2, 1, 0 select sets A, B, C. Set index k is 0 for no module, 1..3 for buffer-only A..C and 4..6 for PLL A..C. PLL index j is 0 for no module and 1..3 for PLL A..C. Reads come from 15002+16k (16 bytes, RF), then 15130+16k (16 bytes, sampling), then 15258+80j (40 bytes, PLL).
- R5: The PLL set is copied only for the no-module and PLL-module cases. With a buffer-only module no PLL bytes are read and no PLL write is issued.
- R6: Scratch bytes are taken as address/data pairs (address first). A device's writes stop at an address byte of 0xFF, or after 8 pairs for each buffer and 20 pairs for the PLL.
- R7: Writes go to the RF buffer first, then the sampling buffer, then the PLL. spi_sel is one-hot during a write: bit 0 selects the RF buffer, bit 1 the sampling buffer, bit 2 the PLL.
- R8: With a PLL module, refmon_en rises after the sampling-buffer writes and no PLL write is issued until refclk_ok is 1. cfg_done does not rise before pll_lock is 1.
- R9: At the end cfg_done is 1 and stays 1 whatever the inputs do. ee_req, spi_req, spi_sel, spi_addr, spi_data and refmon_en are then 0.
- R10: A read error during the copy phase sets cfg_err to 1 and restarts the copy from the default tables.
- R11: Default pair p of device d in set k has address byte d*64+k*8+p and data byte DEF_SEED xor (k*16+d*4+p) for p < DEF_PAIRS. It is followed by an address of 0xFF.
- R12: ee_req holds with a stable ee_addr until ee_ack. spi_req holds with stable spi_sel, spi_addr and spi_data until spi_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw | input | 3 | Module/set switches |
| ee_req | output | 1 | EEPROM byte read request |
| ee_addr | output | 14 | EEPROM byte address |
| ee_ack | input | 1 | Read complete, data valid |
| ee_data | input | 8 | Read byte |
| ee_err | input | 1 | Read failed (valid with ee_ack) |
| spi_req | output | 1 | SPI register write request |
| spi_sel | output | 3 | One-hot device select |
| spi_addr | output | 8 | Register address |
| spi_data | output | 8 | Register data |
| spi_ack | input | 1 | Write complete |
| refmon_en | output | 1 | Reference clock monitor enable |
| refclk_ok | input | 1 | Reference clock valid |
| pll_lock | input | 1 | PLL locked |
| cfg_done | output | 1 | Configuration complete |
| cfg_err | output | 1 | EEPROM read failed during copy |

## Verification
The sequence is run for each module type: a PLL module with set A, a buffer-only module with set B and no module. Each run uses a valid signature and distinct EEPROM contents, so the read addresses and logged SPI writes show the set index, whether the PLL set is copied, and where the write lists stop. Some lists run to their pair limit and others end at a 0xFF address. Separate runs use a wrong second signature byte (PLL set C), a read error on the first signature byte and a read error in the middle of the sampling copy. These distinguish a plain fallback to defaults from the error-flagged fallback and check the computed default tables. The PLL run holds refclk_ok and pll_lock low to show that the PLL writes and the done flag wait on them.

// File: rtl/clkcfg_boot_seq.sv
module clkcfg_boot_seq #(
  parameter int DELAY_CYCLES = 200000,
  parameter int EE_AW        = 14,
  parameter int SIG_ADDR     = 15000,
  parameter logic [7:0] SIG_B0 = 8'hA5,
  parameter logic [7:0] SIG_B1 = 8'hCD,
  parameter int RF_BASE      = 15002,
  parameter int SAMP_BASE    = 15130,
  parameter int PLL_BASE     = 15258,
  parameter int PLL_STRIDE   = 80,
  parameter int BUF_BYTES    = 16,
  parameter int PLL_BYTES    = 40,
  parameter int RAM_BYTES    = 128,
  parameter int DEF_PAIRS    = 3,
  parameter logic [7:0] DEF_SEED = 8'h3C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sw,
  output logic             ee_req,
  output logic [EE_AW-1:0] ee_addr,
  input  logic             ee_ack,
  input  logic [7:0]       ee_data,
  input  logic             ee_err,
  output logic             spi_req,
  output logic [2:0]       spi_sel,
  output logic [7:0]       spi_addr,
  output logic [7:0]       spi_data,
  input  logic             spi_ack,
  output logic             refmon_en,
  input  logic             refclk_ok,
  input  logic             pll_lock,
  output logic             cfg_done,
  output logic             cfg_err
);
  localparam int DW     = $clog2(DELAY_CYCLES + 1);
  localparam int RAM_AW = $clog2(RAM_BYTES);
  localparam int OFFW   = $clog2(PLL_BYTES + 1);

  typedef enum logic [3:0] {
    ST_WAIT, ST_FILL, ST_SIG0, ST_SIG1, ST_DECODE,
    ST_COPY, ST_WRITE, ST_REF, ST_LOCK, ST_DONE
  } state_t;

  state_t            state;
  logic [DW-1:0]     dly_cnt;
  logic [RAM_AW-1:0] fill_idx;
  logic [7:0]        mem [RAM_BYTES];
  logic              use_rom, mod_none, mod_pll, mod_buf;
  logic [1:0]        letter, region, dev;
  logic [OFFW-1:0]   boff, woff, reg_len, wr_len;
  logic [2:0]        kset, jset;
  int                ee_base;
  logic [RAM_AW-1:0] wr_ptr;
  logic [7:0]        cur_addr, cur_data;
  logic              mem_we;
  logic [RAM_AW-1:0] mem_wa;
  logic [7:0]        mem_wd;
  logic              cp_last, wr_last;

  function automatic logic [7:0] rom_byte(int k, int d, int b);
    int p;
    p = b / 2;
    if (p >= DEF_PAIRS) return 8'hFF;
    if (b % 2 == 0) return 8'(d * 64 + k * 8 + p);
    return DEF_SEED ^ 8'(k * 16 + d * 4 + p);
  endfunction

  assign mod_buf = !mod_none && !mod_pll;
  assign kset = mod_none ? 3'd0 : (mod_pll ? 3'd4 : 3'd1) + {1'b0, letter};
  assign jset = mod_none ? 3'd0 : 3'd1 + {1'b0, letter};
  assign reg_len = (region == 2'd2) ? OFFW'(PLL_BYTES) : OFFW'(BUF_BYTES);
  assign wr_len  = (dev == 2'd2) ? OFFW'(PLL_BYTES) : OFFW'(BUF_BYTES);
  assign cp_last = (boff == reg_len - OFFW'(1));
  assign wr_last = (woff + OFFW'(2) >= wr_len);

  always_comb begin
    case (region)
      2'd0:    ee_base = RF_BASE + BUF_BYTES * int'(kset);
      2'd1:    ee_base = SAMP_BASE + BUF_BYTES * int'(kset);
      default: ee_base = PLL_BASE + PLL_STRIDE * int'(jset);
    endcase
    case (state)
      ST_SIG0: ee_addr = EE_AW'(SIG_ADDR);
      ST_SIG1: ee_addr = EE_AW'(SIG_ADDR + 1);
      default: ee_addr = EE_AW'(ee_base + int'(boff));
    endcase
  end

  assign wr_ptr   = RAM_AW'(int'(dev) * BUF_BYTES + int'(woff));
  assign cur_addr = mem[wr_ptr];
  assign cur_data = mem[wr_ptr + RAM_AW'(1)];
  assign spi_sel  = spi_req ? (3'b001 << dev) : 3'b000;
  assign spi_addr = spi_req ? cur_addr : 8'h00;
  assign spi_data = spi_req ? cur_data : 8'h00;

  assign mem_we = (state == ST_FILL) ||
                  (state == ST_COPY && (use_rom || (ee_req && ee_ack && !ee_err)));
  assign mem_wa = (state == ST_FILL) ? fill_idx
                                     : RAM_AW'(int'(region) * BUF_BYTES + int'(boff));
  assign mem_wd = (state == ST_FILL) ? 8'hFF
                : use_rom ? rom_byte(int'(kset), int'(region), int'(boff)) : ee_data;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAIT;
      dly_cnt   <= '0;
      fill_idx  <= '0;
      use_rom   <= 1'b0;
      mod_none  <= 1'b0;
      mod_pll   <= 1'b0;
      letter    <= 2'd0;
      region    <= 2'd0;
      boff      <= '0;
      dev       <= 2'd0;
      woff      <= '0;
      ee_req    <= 1'b0;
      spi_req   <= 1'b0;
      refmon_en <= 1'b0;
      cfg_done  <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      case (state)
        ST_WAIT:
          if (dly_cnt == DW'(DELAY_CYCLES - 1)) state <= ST_FILL;
          else dly_cnt <= dly_cnt + DW'(1);
        ST_FILL: begin
          fill_idx <= fill_idx + RAM_AW'(1);
          if (fill_idx == RAM_AW'(RAM_BYTES - 1)) state <= ST_SIG0;
        end
        ST_SIG0, ST_SIG1:
          if (!ee_req) ee_req <= 1'b1;
          else if (ee_ack) begin
            ee_req <= 1'b0;
            if (ee_err || ee_data != ((state == ST_SIG0) ? SIG_B0 : SIG_B1)) begin
              use_rom <= 1'b1;
              state   <= ST_DECODE;
            end else if (state == ST_SIG0) state <= ST_SIG1;
            else begin
              use_rom <= 1'b0;
              state   <= ST_DECODE;
            end
          end
        ST_DECODE: begin
          mod_none <= (sw[1:0] == 2'd3);
          mod_pll  <= (sw[1:0] != 2'd3) && !sw[2];
          letter   <= 2'd2 - sw[1:0];
          region   <= 2'd0;
          boff     <= '0;
          state    <= ST_COPY;
        end
        ST_COPY:
          if (!use_rom && !ee_req) ee_req <= 1'b1;
          else if (use_rom || ee_ack) begin
            ee_req <= 1'b0;
            if (!use_rom && ee_err) begin
              cfg_err <= 1'b1;
              use_rom <= 1'b1;
              region  <= 2'd0;
              boff    <= '0;
            end else if (!cp_last) boff <= boff + OFFW'(1);
            else begin
              boff <= '0;
              if (region == 2'd0) region <= 2'd1;
              else if (region == 2'd1 && !mod_buf) region <= 2'd2;
              else begin
                dev   <= 2'd0;
                woff  <= '0;
                state <= ST_WRITE;
              end
            end
          end
        ST_WRITE:
          if ((!spi_req && cur_addr == 8'hFF) || (spi_req && spi_ack && wr_last)) begin
            spi_req <= 1'b0;
            woff    <= '0;
            case (dev)
              2'd0: dev <= 2'd1;
              2'd1:
                if (mod_pll) begin
                  refmon_en <= 1'b1;
                  state     <= ST_REF;
                end else dev <= 2'd2;
              default: state <= mod_pll ? ST_LOCK : ST_DONE;
            endcase
          end else if (!spi_req) spi_req <= 1'b1;
          else if (spi_ack) begin
            spi_req <= 1'b0;
            woff    <= woff + OFFW'(2);
          end
        ST_REF:
          if (refclk_ok) begin
            dev   <= 2'd2;
            woff  <= '0;
            state <= ST_WRITE;
          end
        ST_LOCK:
          if (pll_lock) state <= ST_DONE;
        default: begin
          cfg_done  <= 1'b1;
          refmon_en <= 1'b0;
          ee_req    <= 1'b0;
          spi_req   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/clkcfg_boot_seq_chk.sv
module clkcfg_boot_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ee_req,
  input logic [13:0] ee_addr,
  input logic        ee_ack,
  input logic        spi_req,
  input logic [2:0]  spi_sel,
  input logic [7:0]  spi_addr,
  input logic [7:0]  spi_data,
  input logic        spi_ack,
  input logic        refmon_en,
  input logic        pll_lock,
  input logic        cfg_done,
  input logic        mod_pll
);
  p_ee_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ee_ack |=> ee_req && $stable(ee_addr));

  p_spi_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req && !spi_ack |=> spi_req && $stable(spi_sel) && $stable(spi_addr) && $stable(spi_data));

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> $countones(spi_sel) == 1);

  p_ref_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req && spi_sel[2] && mod_pll |-> refmon_en);

  p_lock_before_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) && mod_pll |-> $past(pll_lock));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !spi_req && !ee_req && !refmon_en && spi_sel == 3'b000);
endmodule

bind clkcfg_boot_seq clkcfg_boot_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ee_req(ee_req), .ee_addr(ee_addr), .ee_ack(ee_ack),
  .spi_req(spi_req), .spi_sel(spi_sel), .spi_addr(spi_addr), .spi_data(spi_data),
  .spi_ack(spi_ack), .refmon_en(refmon_en), .pll_lock(pll_lock),
  .cfg_done(cfg_done), .mod_pll(mod_pll)
);

// File: tb/clkcfg_boot_seq_test.sv
module clkcfg_boot_seq_test;
  localparam int D = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  sw = 3'b111;
  logic        ee_req, ee_ack = 1'b0, ee_err = 1'b0;
  logic [13:0] ee_addr;
  logic [7:0]  ee_data = 8'h00;
  logic        spi_req, spi_ack = 1'b0;
  logic [2:0]  spi_sel;
  logic [7:0]  spi_addr, spi_data;
  logic        refmon_en, refclk_ok = 1'b0, pll_lock = 1'b0;
  logic        cfg_done, cfg_err;

  clkcfg_boot_seq #(.DELAY_CYCLES(D)) uut (
    .clk(clk), .rst_n(rst_n), .sw(sw),
    .ee_req(ee_req), .ee_addr(ee_addr), .ee_ack(ee_ack), .ee_data(ee_data), .ee_err(ee_err),
    .spi_req(spi_req), .spi_sel(spi_sel), .spi_addr(spi_addr), .spi_data(spi_data),
    .spi_ack(spi_ack), .refmon_en(refmon_en), .refclk_ok(refclk_ok), .pll_lock(pll_lock),
    .cfg_done(cfg_done), .cfg_err(cfg_err)
  );

  int checks = 0, fails = 0;
  int ee_log [0:255];
  int ee_n = 0;
  logic [2:0] wsel [0:63];
  logic [7:0] waddr [0:63];
  logic [7:0] wdata [0:63];
  int wn = 0;
  int hold_bad = 0;
  bit refmon_seen = 1'b0;
  logic [7:0] sig0 = 8'hA5, sig1 = 8'hCD;
  int pairs [3];
  int err_addr = -1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ee_byte(int a);
    int o, n;
    if (a == 15000) return sig0;
    if (a == 15001) return sig1;
    if (a >= 15002 && a < 15114) begin o = (a - 15002) % 16; n = pairs[0]; end
    else if (a >= 15130 && a < 15242) begin o = (a - 15130) % 16; n = pairs[1]; end
    else if (a >= 15258 && a < 15578) begin o = (a - 15258) % 80; n = pairs[2]; end
    else return 8'h00;
    if (o % 2 == 0) return (o / 2 < n) ? 8'(a & 127) : 8'hFF;
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rom_b(int k, int d, int p, bit dat);
    if (dat) return 8'h3C ^ 8'(k * 16 + d * 4 + p);
    return 8'(d * 64 + k * 8 + p);
  endfunction

  // EEPROM reader model
  initial forever begin
    int rec;
    @(negedge clk);
    ee_ack = 1'b0;
    if (rst_n && ee_req) begin
      rec = int'(ee_addr);
      if (ee_n < 256) ee_log[ee_n] = rec;
      ee_n++;
      @(negedge clk);
      if (int'(ee_addr) != rec || !ee_req) hold_bad++;
      ee_data = ee_byte(rec);
      ee_err  = (rec == err_addr);
      ee_ack  = 1'b1;
      @(negedge clk);
      ee_ack = 1'b0;
    end
  end

  // SPI writer model
  initial forever begin
    logic [7:0] ra;
    @(negedge clk);
    spi_ack = 1'b0;
    if (rst_n && spi_req) begin
      ra = spi_addr;
      if (wn < 64) begin
        wsel[wn] = spi_sel; waddr[wn] = spi_addr; wdata[wn] = spi_data;
      end
      wn++;
      repeat (2) @(negedge clk);
      if (spi_addr != ra || !spi_req) hold_bad++;
      spi_ack = 1'b1;
      @(negedge clk);
      spi_ack = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && refmon_en) refmon_seen = 1'b1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic start_run(logic [2:0] s, logic [7:0] b1, int p0, int p1, int p2,
                           int ea, logic rc, logic lk);
    @(negedge clk);
    rst_n = 1'b0;
    sw = s; sig0 = 8'hA5; sig1 = b1;
    pairs[0] = p0; pairs[1] = p1; pairs[2] = p2;
    err_addr = ea; refclk_ok = rc; pll_lock = lk;
    repeat (3) @(negedge clk);
    ee_n = 0; wn = 0; hold_bad = 0; refmon_seen = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !cfg_done; i++) @(negedge clk);
  endtask

  task automatic chk_dev(string tag, int d, int start, int n, bit rom, int k, int base);
    int bad;
    bad = -1;
    for (int i = 0; i < n; i++) begin
      logic [7:0] ea, ed;
      ea = rom ? rom_b(k, d, i, 1'b0) : ee_byte(base + 2 * i);
      ed = rom ? rom_b(k, d, i, 1'b1) : ee_byte(base + 2 * i + 1);
      if ((wsel[start + i] != (3'b001 << d) || waddr[start + i] != ea ||
           wdata[start + i] != ed) && bad < 0) bad = i;
    end
    chk(bad < 0, tag, bad, -1);
  endtask

  task automatic chk_end_state(string tag);
    chk(cfg_done && !spi_req && !ee_req && !refmon_en && spi_sel == 3'b000 &&
        spi_addr == 8'h00 && spi_data == 8'h00, tag, int'(cfg_done), 1);
  endtask

  task automatic t_reset();
    int n;
    start_run(3'b111, 8'hCD, 1, 1, 1, -1, 1'b1, 1'b1);
    chk(!cfg_done && !cfg_err && !ee_req && !spi_req, "R1 reset outputs", int'(cfg_done), 0);
    n = 0;
    while (!ee_req && n < 1000) begin
      @(negedge clk);
      if (!ee_req) n++;
    end
    chk(n >= D + 128 && n <= D + 131, "R1 delay before first read", n, D + 128);
    wait_done();
  endtask

  task automatic t_pll_a();
    int i;
    start_run(3'b010, 8'hCD, 8, 2, 20, -1, 1'b0, 1'b0);
    i = 0;
    while (!refmon_en && i < 5000) begin @(negedge clk); i++; end
    repeat (20) @(negedge clk);
    chk(refmon_en && wn == 10, "R8 PLL writes held for refclk", wn, 10);
    refclk_ok = 1'b1;
    i = 0;
    while (wn < 30 && i < 5000) begin @(negedge clk); i++; end
    repeat (30) @(negedge clk);
    chk(!cfg_done && wn == 30, "R8 done held for lock (R6 limits)", wn, 30);
    pll_lock = 1'b1;
    repeat (5) @(negedge clk);
    chk(cfg_done, "R8 done after lock", int'(cfg_done), 1);
    chk(ee_n == 74 && ee_log[0] == 15000 && ee_log[1] == 15001, "R2 signature reads", ee_n, 74);
    chk(ee_log[2] == 15066 && ee_log[18] == 15194 && ee_log[34] == 15338,
        "R4 PLL A addresses", ee_log[34], 15338);
    chk_dev("R7 R6 rf writes", 0, 0, 8, 1'b0, 0, 15066);
    chk_dev("R7 R6 samp writes", 1, 8, 2, 1'b0, 0, 15194);
    chk_dev("R7 pll writes", 2, 10, 20, 1'b0, 0, 15338);
    chk(hold_bad == 0, "R12 request hold", hold_bad, 0);
    chk_end_state("R9 end outputs");
    pll_lock = 1'b0; refclk_ok = 1'b0;
    repeat (10) @(negedge clk);
    chk(cfg_done, "R9 done sticky", int'(cfg_done), 1);
  endtask

  task automatic t_buf_b();
    start_run(3'b101, 8'hCD, 3, 8, 20, -1, 1'b0, 1'b0);
    wait_done();
    chk(cfg_done && !refmon_seen, "R3 buffer module no refmon", int'(refmon_seen), 0);
    chk(ee_n == 34, "R5 no PLL reads", ee_n, 34);
    chk(ee_log[2] == 15034 && ee_log[18] == 15162, "R4 buffer B addresses", ee_log[2], 15034);
    chk(wn == 11, "R5 no PLL writes", wn, 11);
    chk_dev("R6 rf stop at FF", 0, 0, 3, 1'b0, 0, 15034);
    chk_dev("R6 samp limit", 1, 3, 8, 1'b0, 0, 15162);
  endtask

  task automatic t_none();
    start_run(3'b111, 8'hCD, 2, 5, 6, -1, 1'b0, 1'b0);
    wait_done();
    chk(cfg_done && !refmon_seen, "R3 no module no waits", int'(cfg_done), 1);
    chk(ee_n == 74 && ee_log[2] == 15002 && ee_log[18] == 15130 && ee_log[34] == 15258,
        "R4 R5 no-module addresses", ee_log[34], 15258);
    chk(wn == 13, "R5 no-module writes", wn, 13);
    chk_dev("R7 pll set no module", 2, 7, 6, 1'b0, 0, 15258);
  endtask

  task automatic t_bad_sig();
    start_run(3'b000, 8'hCE, 8, 8, 20, -1, 1'b1, 1'b1);
    wait_done();
    chk(ee_n == 2 && !cfg_err, "R2 bad signature stops reads", ee_n, 2);
    chk(wn == 3 * 3, "R11 default count", wn, 9);
    chk_dev("R11 default rf set C", 0, 0, 3, 1'b1, 6, 0);
    chk_dev("R11 default samp set C", 1, 3, 3, 1'b1, 6, 0);
    chk_dev("R11 default pll set C", 2, 6, 3, 1'b1, 6, 0);
  endtask

  task automatic t_sig_err();
    start_run(3'b011, 8'hCD, 8, 8, 20, 15000, 1'b0, 1'b0);
    wait_done();
    chk(ee_n == 1 && !cfg_err && cfg_done, "R2 signature read error", ee_n, 1);
    chk(wn == 9, "R11 defaults no module", wn, 9);
    chk_dev("R11 default pll no module", 2, 6, 3, 1'b1, 0, 0);
  endtask

  task automatic t_copy_err();
    start_run(3'b110, 8'hCD, 8, 8, 20, 15150, 1'b0, 1'b0);
    wait_done();
    chk(cfg_err, "R10 error flag", int'(cfg_err), 1);
    chk(ee_n == 23, "R10 reads stop at error", ee_n, 23);
    chk(wn == 6, "R10 default writes", wn, 6);
    chk_dev("R10 default rf set", 0, 0, 3, 1'b1, 1, 0);
    chk_dev("R10 default samp set", 1, 3, 3, 1'b1, 1, 0);
  endtask

  initial begin
    pairs[0] = 1; pairs[1] = 1; pairs[2] = 1;
    t_reset();
    t_pll_a();
    t_buf_b();
    t_none();
    t_bad_sig();
    t_sig_err();
    t_copy_err();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule